// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block is a small direct-mapped cache between a processor port and a backing memory port. It has four lines. Each line holds one 32-bit word, which is a 4-byte block, together with a tag, a valid flag and a dirty flag. A processor address divides into three fields. Bits [1:0] are the byte offset, which is ignored because every access is a whole word. Bits [3:2] select the line. The upper bits form the tag.

A static mode pin picks one of two policy pairs:

- **Mode 0: write-through with no-write-allocate.** A write hit updates the line and also writes memory at once. A write miss goes straight to memory and leaves the cache unchanged.
- **Mode 1: write-back with write-allocate.** A write hit only updates the line and marks it dirty. A write miss first fetches the block and then merges the store into the line. A dirty line is written to memory only when a miss replaces it, and that write-back happens before the new block is fetched.

The mode must only change while reset is held. Read misses allocate in both modes.

The processor request channel is valid/ready. A request transfers on a cycle where both `cpu_req_valid_i` and `cpu_req_ready_o` are high. Ready is high only when the cache is idle, so at most one access is in flight. The response channel is also valid/ready. Once `cpu_rsp_valid_o` rises, the response data and hit flag hold steady until `cpu_rsp_ready_i` is high at a clock edge. The memory channel is a request/acknowledge pair. While `mem_req_valid_o` is high, its address, write flag and write data are held until the cycle in which `mem_req_ready_i` is high. For a read, `mem_rdata_i` is taken in that same cycle.

Top module: `dmc_wpol_cache`

## Requirements
- R1: Address bits [1:0] never affect the result. Bits [3:2] select the line and bits [7:4] are compared as the tag. Every memory request carries a word address with bits [1:0] equal to zero.
- R2: Reset clears every valid and dirty flag, so the first read after reset misses and fetches from memory.
- R3: A read hit returns the cached word with `cpu_rsp_hit_o`=1 and raises no memory request.
- R4: A read miss, in either mode, issues one memory read of the block, installs it, and returns the fetched word with `cpu_rsp_hit_o`=0.
- R5: In mode 0, a write hit updates the line and issues exactly one memory write of the store data. A following read hits and returns the new word.
- R6: In mode 0, a write miss issues exactly one memory write and installs nothing, so a following read of that address misses.
- R7: In mode 1, a write hit causes no memory traffic. A following read hits and returns the stored word.
- R8: In mode 1, a write miss issues a memory read of the block and then keeps the store data in the line as dirty. No memory write of the store occurs.
- R9: In mode 1, a miss whose line holds a dirty block first writes that block (old tag, same index) to memory, then reads the new block. A clean or invalid victim goes straight to the read.
- R10: A miss replaces whatever block occupies the selected line, so the displaced address misses on its next access.
- R11: Memory request fields stay stable until acknowledged. Response fields stay stable until accepted. No new processor request is accepted while an access is in flight.
- R12: In mode 0 no line ever becomes dirty, so evictions in mode 0 never write memory.
- R13: A write response returns the store data as `cpu_rsp_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_mode_i | input | 1 | 0: write-through/no-allocate, 1: write-back/allocate (static) |
| cpu_req_valid_i | input | 1 | Processor request valid |
| cpu_req_ready_o | output | 1 | Cache can accept a request |
| cpu_req_we_i | input | 1 | 1 = write, 0 = read |
| cpu_req_addr_i | input | 8 | Byte address |
| cpu_req_wdata_i | input | 32 | Store data |
| cpu_rsp_valid_o | output | 1 | Response valid |
| cpu_rsp_ready_i | input | 1 | Processor accepts response |
| cpu_rsp_rdata_o | output | 32 | Load data (store data for writes) |
| cpu_rsp_hit_o | output | 1 | Access hit in the cache |
| mem_req_valid_o | output | 1 | Memory request pending |
| mem_req_ready_i | input | 1 | Memory acknowledge |
| mem_req_we_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | 8 | Word-aligned memory address |
| mem_req_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |

## Verification
Two of this block's functions can land in the same cycle: the block install and the processor store merge. On a write-allocate miss, the memory acknowledge that returns the block is also the cycle in which the store is merged into the line and the line is marked dirty. The bench provokes this with write misses in mode 1, one into an empty line and one whose victim is dirty, with acknowledge latencies that vary between zero and two wait cycles. It judges the result in two ways. A later read must hit with the store data, not the fetched word. A later eviction must write the store data back to the old address before the new block is read.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB,
    ST_FILL,
    ST_WTHRU,
    ST_RESP
  } dmc_state_e;

endpackage

// File: rtl/dmc_addr_split.sv
`timescale 1ns/1ps
module dmc_addr_split #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o
);

  // Byte offset selects nothing: every access is one whole word.
  logic unused_off;
  assign unused_off = ^addr_i[OFF_W-1:0];

  assign idx_o = addr_i[OFF_W +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/dmc_line_store.sv
`timescale 1ns/1ps
module dmc_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_mode_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_dirty_i
);

  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] dirty_vec;
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q;
    logic              d_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] w_q;
    logic              sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        d_q <= wr_dirty_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        t_q <= wr_tag_i;
        w_q <= wr_data_i;
      end
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign tag_arr[g]   = t_q;
    assign data_arr[g]  = w_q;
  end

  assign rd_valid_o = valid_vec[rd_idx_i];
  assign rd_dirty_o = dirty_vec[rd_idx_i];
  assign rd_tag_o   = tag_arr[rd_idx_i];
  assign rd_data_o  = data_arr[rd_idx_i];

  // R12: write-through operation never leaves a dirty line behind
  a_r12_clean_in_wt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_mode_i |-> (dirty_vec == '0));

  // R2: a line cannot be dirty without being valid
  a_r2_dirty_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dirty_vec & ~valid_vec) == '0));

endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_mode_i,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_we_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [DATA_W-1:0] cpu_req_wdata_i,
  output logic              cpu_rsp_valid_o,
  input  logic              cpu_rsp_ready_i,
  output logic [DATA_W-1:0] cpu_rsp_rdata_o,
  output logic              cpu_rsp_hit_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  st_rd_idx_o,
  input  logic              st_rd_valid_i,
  input  logic              st_rd_dirty_i,
  input  logic [TAG_W-1:0]  st_rd_tag_i,
  input  logic [DATA_W-1:0] st_rd_data_i,
  output logic              st_wr_en_o,
  output logic [IDX_W-1:0]  st_wr_idx_o,
  output logic [TAG_W-1:0]  st_wr_tag_o,
  output logic [DATA_W-1:0] st_wr_data_o,
  output logic              st_wr_dirty_o
);

  dmc_state_e        state_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic              hit;
  logic              dirty_victim;
  logic              mem_ack;

  dmc_addr_split #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) u_split (
    .addr_i (req_addr_q),
    .tag_o  (req_tag),
    .idx_o  (req_idx)
  );

  assign st_rd_idx_o  = req_idx;
  assign hit          = st_rd_valid_i && (st_rd_tag_i == req_tag);
  assign dirty_victim = wb_mode_i && st_rd_valid_i && st_rd_dirty_i;
  assign mem_ack      = mem_req_valid_o && mem_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rsp_data_q  <= '0;
      rsp_hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req_valid_i) begin
            req_we_q    <= cpu_req_we_i;
            req_addr_q  <= cpu_req_addr_i;
            req_wdata_q <= cpu_req_wdata_i;
            rsp_data_q  <= cpu_req_wdata_i;
            state_q     <= ST_CMP;
          end
        end
        ST_CMP: begin
          rsp_hit_q <= hit;
          if (!req_we_q) begin
            if (hit) begin
              rsp_data_q <= st_rd_data_i;
              state_q    <= ST_RESP;
            end else begin
              state_q <= dirty_victim ? ST_WB : ST_FILL;
            end
          end else if (wb_mode_i) begin
            if (hit) state_q <= ST_RESP;
            else     state_q <= dirty_victim ? ST_WB : ST_FILL;
          end else begin
            state_q <= ST_WTHRU;
          end
        end
        ST_WB: begin
          if (mem_req_ready_i) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_req_ready_i) begin
            if (!req_we_q) rsp_data_q <= mem_rdata_i;
            state_q <= ST_RESP;
          end
        end
        ST_WTHRU: begin
          if (mem_req_ready_i) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (cpu_rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Line store write port: store merge on a hit, install on a fill acknowledge.
  always_comb begin
    st_wr_en_o    = 1'b0;
    st_wr_idx_o   = req_idx;
    st_wr_tag_o   = req_tag;
    st_wr_data_o  = req_wdata_q;
    st_wr_dirty_o = 1'b0;
    if (state_q == ST_CMP && req_we_q && hit) begin
      st_wr_en_o    = 1'b1;
      st_wr_dirty_o = wb_mode_i;
    end else if (state_q == ST_FILL && mem_req_ready_i) begin
      st_wr_en_o    = 1'b1;
      st_wr_data_o  = req_we_q ? req_wdata_q : mem_rdata_i;
      st_wr_dirty_o = req_we_q;
    end
  end

  // Memory request channel
  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = {req_tag, req_idx, {OFF_W{1'b0}}};
    mem_req_wdata_o = req_wdata_q;
    unique case (state_q)
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = {st_rd_tag_i, req_idx, {OFF_W{1'b0}}};
        mem_req_wdata_o = st_rd_data_i;
      end
      ST_FILL: begin
        mem_req_valid_o = 1'b1;
      end
      ST_WTHRU: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign cpu_req_ready_o = (state_q == ST_IDLE);
  assign cpu_rsp_valid_o = (state_q == ST_RESP);
  assign cpu_rsp_rdata_o = rsp_data_q;
  assign cpu_rsp_hit_o   = rsp_hit_q;

  // R11: memory request fields hold while waiting for acknowledge
  a_r11_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
       && $stable(mem_req_wdata_o)));

  // R11: response fields hold until accepted
  a_r11_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rsp_valid_o && !cpu_rsp_ready_i) |=>
      (cpu_rsp_valid_o && $stable(cpu_rsp_rdata_o) && $stable(cpu_rsp_hit_o)));

  // R11: single access in flight
  a_r11_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_ready_o |-> (!mem_req_valid_o && !cpu_rsp_valid_o));

  // R9: an acknowledged victim write is followed by the block read
  a_r9_wb_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ack && mem_req_we_o && wb_mode_i) |=> (mem_req_valid_o && !mem_req_we_o));

  // R3: a read hit response is reached without memory traffic
  a_r3_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_rsp_valid_o) && cpu_rsp_hit_o && !req_we_q) |-> $past(!mem_req_valid_o));

  // R1: memory addresses are word aligned
  a_r1_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[OFF_W-1:0] == '0));

endmodule

// File: rtl/dmc_wpol_cache.sv
`timescale 1ns/1ps
module dmc_wpol_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_mode_i,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_we_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [DATA_W-1:0] cpu_req_wdata_i,
  output logic              cpu_rsp_valid_o,
  input  logic              cpu_rsp_ready_i,
  output logic [DATA_W-1:0] cpu_rsp_rdata_o,
  output logic              cpu_rsp_hit_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic [IDX_W-1:0]  st_rd_idx;
  logic              st_rd_valid;
  logic              st_rd_dirty;
  logic [TAG_W-1:0]  st_rd_tag;
  logic [DATA_W-1:0] st_rd_data;
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [TAG_W-1:0]  st_wr_tag;
  logic [DATA_W-1:0] st_wr_data;
  logic              st_wr_dirty;

  dmc_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wb_mode_i       (wb_mode_i),
    .cpu_req_valid_i (cpu_req_valid_i),
    .cpu_req_ready_o (cpu_req_ready_o),
    .cpu_req_we_i    (cpu_req_we_i),
    .cpu_req_addr_i  (cpu_req_addr_i),
    .cpu_req_wdata_i (cpu_req_wdata_i),
    .cpu_rsp_valid_o (cpu_rsp_valid_o),
    .cpu_rsp_ready_i (cpu_rsp_ready_i),
    .cpu_rsp_rdata_o (cpu_rsp_rdata_o),
    .cpu_rsp_hit_o   (cpu_rsp_hit_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_we_o    (mem_req_we_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o),
    .mem_rdata_i     (mem_rdata_i),
    .st_rd_idx_o     (st_rd_idx),
    .st_rd_valid_i   (st_rd_valid),
    .st_rd_dirty_i   (st_rd_dirty),
    .st_rd_tag_i     (st_rd_tag),
    .st_rd_data_i    (st_rd_data),
    .st_wr_en_o      (st_wr_en),
    .st_wr_idx_o     (st_wr_idx),
    .st_wr_tag_o     (st_wr_tag),
    .st_wr_data_o    (st_wr_data),
    .st_wr_dirty_o   (st_wr_dirty)
  );

  dmc_line_store #(
    .LINES  (LINES),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_mode_i  (wb_mode_i),
    .rd_idx_i   (st_rd_idx),
    .rd_valid_o (st_rd_valid),
    .rd_dirty_o (st_rd_dirty),
    .rd_tag_o   (st_rd_tag),
    .rd_data_o  (st_rd_data),
    .wr_en_i    (st_wr_en),
    .wr_idx_i   (st_wr_idx),
    .wr_tag_i   (st_wr_tag),
    .wr_data_i  (st_wr_data),
    .wr_dirty_i (st_wr_dirty)
  );

endmodule

// File: tb/dmc_wpol_cache_tb_top.sv
`timescale 1ns/1ps
module dmc_wpol_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_we = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b0;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_hit;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [7:0]  mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dmc_wpol_cache dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .wb_mode_i       (wb_mode),
    .cpu_req_valid_i (cpu_req_valid),
    .cpu_req_ready_o (cpu_req_ready),
    .cpu_req_we_i    (cpu_req_we),
    .cpu_req_addr_i  (cpu_req_addr),
    .cpu_req_wdata_i (cpu_req_wdata),
    .cpu_rsp_valid_o (cpu_rsp_valid),
    .cpu_rsp_ready_i (cpu_rsp_ready),
    .cpu_rsp_rdata_o (cpu_rsp_rdata),
    .cpu_rsp_hit_o   (cpu_rsp_hit),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_ready_i (mem_req_ready),
    .mem_req_we_o    (mem_req_we),
    .mem_req_addr_o  (mem_req_addr),
    .mem_req_wdata_o (mem_req_wdata),
    .mem_rdata_i     (mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rsp_seen = 0;
  bit finished = 1'b0;
  string cur_tag = "";

  logic [31:0] mem   [64];
  logic [31:0] shadow[64];
  logic [32:0] rsp_q[$];      // {hit, data}
  string       rsp_tag_q[$];
  logic [40:0] mem_q[$];      // {we, addr, data}

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_mem(bit we, logic [7:0] a, logic [31:0] d);
    mem_q.push_back({we, a, d});
  endtask

  task automatic access(bit we, logic [7:0] a, logic [31:0] d, bit hit, string tag);
    logic [31:0] exp;
    int target;
    exp = we ? d : shadow[a[7:2]];
    if (we) shadow[a[7:2]] = d;
    rsp_q.push_back({hit, exp});
    rsp_tag_q.push_back(tag);
    cur_tag = tag;
    target = rsp_seen + 1;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (rsp_seen < target) @(negedge clk);
  endtask

  // Memory responder, response acceptor and scoreboard monitor
  int          lat = 0;
  int          txn = 0;
  bit          mem_wait = 1'b0;
  logic [40:0] mem_prev;
  bit          rsp_wait = 1'b0;
  logic [32:0] rsp_prev;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // memory side
      if (mem_req_ready) begin
        mem_req_ready <= 1'b0;
        lat = 0;
        mem_wait = 1'b0;
      end else if (mem_req_valid) begin
        if (mem_wait)
          check(mem_prev == {mem_req_we, mem_req_addr, mem_req_wdata}, "R11",
                "memory request held", {23'd0, mem_req_we, mem_req_addr, mem_req_wdata},
                {23'd0, mem_prev});
        if (lat == txn % 3) begin
          logic [40:0] e;
          txn++;
          if (mem_q.size() == 0) begin
            check(1'b0, cur_tag, "unexpected memory request", {23'd0, mem_req_we, mem_req_addr,
                  mem_req_wdata}, 64'd0);
          end else begin
            e = mem_q.pop_front();
            check(e[40] == mem_req_we && e[39:32] == mem_req_addr &&
                  (!e[40] || e[31:0] == mem_req_wdata), cur_tag, "memory request",
                  {23'd0, mem_req_we, mem_req_addr, mem_req_we ? mem_req_wdata : 32'd0},
                  {23'd0, e[40], e[39:32], e[40] ? e[31:0] : 32'd0});
          end
          if (mem_req_we) mem[mem_req_addr[7:2]] = mem_req_wdata;
          else            mem_rdata <= mem[mem_req_addr[7:2]];
          mem_req_ready <= 1'b1;
          mem_wait = 1'b0;
        end else begin
          lat++;
          mem_wait = 1'b1;
          mem_prev = {mem_req_we, mem_req_addr, mem_req_wdata};
        end
      end
      // response side
      if (rsp_wait)
        check(cpu_rsp_valid && rsp_prev == {cpu_rsp_hit, cpu_rsp_rdata}, "R11",
              "response held", {31'd0, cpu_rsp_hit, cpu_rsp_rdata}, {31'd0, rsp_prev});
      cpu_rsp_ready = (cyc % 3 != 0);
      rsp_wait = 1'b0;
      if (cpu_rsp_valid) begin
        if (cpu_rsp_ready) begin
          logic [32:0] e;
          string t;
          e = rsp_q.pop_front();
          t = rsp_tag_q.pop_front();
          check(e == {cpu_rsp_hit, cpu_rsp_rdata}, t, "response {hit,data}",
                {31'd0, cpu_rsp_hit, cpu_rsp_rdata}, {31'd0, e});
          rsp_seen++;
        end else begin
          rsp_wait = 1'b1;
          rsp_prev = {cpu_rsp_hit, cpu_rsp_rdata};
        end
      end
    end
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    wb_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_req_ready && !cpu_rsp_valid && !mem_req_valid, "R2", "idle after reset",
          {61'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 64'b100);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'hA000_0000 | i;
      shadow[i] = mem[i];
    end

    // ---- mode 0: write-through, no-write-allocate ----
    do_reset(1'b0);
    exp_mem(0, 8'h10, 0);
    access(0, 8'h10, 0, 0, "R4 read miss fill");
    access(0, 8'h13, 0, 1, "R1 offset ignored / R3 read hit");
    exp_mem(1, 8'h10, 32'h8);
    access(1, 8'h10, 32'h8, 1, "R5 wt write hit / R13");
    access(0, 8'h10, 0, 1, "R5 line updated");
    exp_mem(1, 8'h24, 32'h9);
    access(1, 8'h26, 32'h9, 0, "R6 wt write miss, word address");
    exp_mem(0, 8'h24, 0);
    access(0, 8'h24, 0, 0, "R6 no allocate");
    exp_mem(0, 8'h20, 0);
    access(0, 8'h20, 0, 0, "R12 clean eviction in wt");
    exp_mem(0, 8'h10, 0);
    access(0, 8'h10, 0, 0, "R10 displaced block misses");

    // ---- mode 1: write-back, write-allocate ----
    do_reset(1'b1);
    exp_mem(0, 8'h10, 0);
    access(0, 8'h10, 0, 0, "R2 reset invalidates");
    access(1, 8'h12, 32'h55, 1, "R7 wb write hit quiet");
    access(0, 8'h10, 0, 1, "R7 read after wb hit");
    exp_mem(0, 8'h34, 0);
    access(1, 8'h34, 32'h66, 0, "R8 write allocate");
    access(0, 8'h34, 0, 1, "R8 merged data hit");
    exp_mem(1, 8'h10, 32'h55);
    exp_mem(0, 8'h50, 0);
    access(0, 8'h50, 0, 0, "R9 dirty victim first");
    exp_mem(0, 8'h60, 0);
    access(0, 8'h60, 0, 0, "R9 clean victim skip");
    exp_mem(0, 8'h10, 0);
    access(0, 8'h10, 0, 0, "R9 written-back data");
    exp_mem(1, 8'h34, 32'h66);
    exp_mem(0, 8'h44, 0);
    access(1, 8'h44, 32'h77, 0, "R8 R9 allocate with dirty victim");
    exp_mem(1, 8'h44, 32'h77);
    exp_mem(0, 8'h34, 0);
    access(0, 8'h34, 0, 0, "R10 R9 merged store written back");

    repeat (4) @(negedge clk);
    check(mem_q.size() == 0 && rsp_q.size() == 0, "R11", "all expected traffic seen",
          mem_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule